// File: doc/BRIEF.md
# Multiplexed GPIO port controller

A register-mapped general-purpose I/O port with up to 32 pins behind a simple single-cycle register bus. Every pin can be an input or an output. Direction changes through a write-one-to-set register and a write-one-to-clear register, so software never needs a read-modify-write. A per-pin alternate-function select hands the pin to a peripheral, which then supplies both the output value and the output enable. The output latch keeps its value while a pin is an input, so a pin turned back into an output drives its last written level.

Every pad input passes through a two-flop synchronizer. The synchronized level can be read back at any time, also for pins that are outputs, and it feeds a per-pin interrupt unit. That unit supports level or edge detection with a selectable polarity. Edge events are held in a write-one-to-clear status register, and all enabled pending bits combine into one interrupt line. Each pin also has a two-bit pull-mode field, which drives pull-up and pull-down enables toward the pad. The `PIN_CNT` parameter sets the number of implemented pins; 31 and 15 are the intended builds.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0), no alternate function is selected, the output latch is 0, `irq` is 0, every pin has pad_pu=1 and pad_pd=0, and every pull field reads 2'b01.
- R2: A write to word address 2 (direction set) sets each direction bit whose write-data bit is 1 and leaves the others alone. Reading address 2 or address 3 returns the current direction of every pin.
- R3: A write to word address 3 (direction clear) clears each direction bit whose write-data bit is 1. Zero bits have no effect.
- R4: The output latch is at address 1. On a pin without an alternate function, pad_out shows the latch and pad_oe shows the direction bit. The latch changes only when address 1 is written, so it survives direction changes.
- R5: Address 0 returns pad_in after the two-flop synchronizer. A pad change becomes visible after the second rising clock edge, whatever the pin's direction.
- R6: Address 4 holds the alternate-function select. A pin whose select bit is 1 drives alt_out onto pad_out and alt_oe onto pad_oe, whatever its latch and direction bits hold.
- R7: Each pin has a 2-bit pull field: 2'b01 pull-up, 2'b10 pull-down, 2'b00 and 2'b11 high impedance. Pins 0-15 sit at address 5 and pins 16-31 at address 6, with pin k at bits 2*(k mod 16)+1:2*(k mod 16).
- R8: Register bits at or above PIN_CNT, and the pull fields of absent pins, read 0 and cannot be written. Unmapped addresses (11-15) read 0 and ignore writes.
- R9: Addresses 7, 8 and 9 hold the interrupt enable, the type (1 = edge, 0 = level) and the polarity (1 = high/rising, 0 = low/falling). For a level pin, status bit 10 reads 1 while the synchronized level equals the polarity bit.
- R10: For an edge pin, a synchronized transition in the selected direction sets a sticky status bit at address 10, one edge after the level becomes visible. Writing 1 to that bit clears it, and the opposite transition does not set it.
- R11: An edge detected in the same cycle as a clear write to its status bit leaves the bit set.
- R12: `irq` is 1 exactly when some pin has both its enable bit and its status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | PIN_CNT | Raw pad levels |
| pad_out | output | PIN_CNT | Pad output value |
| pad_oe | output | PIN_CNT | Pad output enable |
| pad_pu | output | PIN_CNT | Pull-up enable |
| pad_pd | output | PIN_CNT | Pull-down enable |
| alt_out | input | PIN_CNT | Peripheral output value |
| alt_oe | input | PIN_CNT | Peripheral output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that rst_n is released in step with the clock, that bus_sel and bus_wr are held for exactly one sampling edge per access, and that pad_in only changes between clock edges. The bench keeps to these assumptions. It drives every input on the falling edge, holds each write for a single rising edge, and changes pad levels only at falling edges. It times the coincident-clear case so that the clear write is sampled on the very edge that detects the transition.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    REG_DIN    = 4'd0,
    REG_DOUT   = 4'd1,
    REG_OE_SET = 4'd2,
    REG_OE_CLR = 4'd3,
    REG_ALT    = 4'd4,
    REG_PULL_A = 4'd5,
    REG_PULL_B = 4'd6,
    REG_IEN    = 4'd7,
    REG_ITYPE  = 4'd8,
    REG_IPOL   = 4'd9,
    REG_ISTAT  = 4'd10
  } reg_e;

  localparam logic [1:0] PULL_UP   = 2'b01;
  localparam logic [1:0] PULL_DOWN = 2'b10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] etype,
  input  logic [W-1:0] pol,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat,
  output logic         irq
);
  logic [W-1:0] prev_q, edge_q, edge_d, rise, fall, hit, clr;

  always_comb begin
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
    hit    = etype & ((pol & rise) | (~pol & fall));
    clr    = clr_we ? clr_mask : '0;
    edge_d = (edge_q & ~clr) | hit;
    stat   = (etype & edge_q) | (~etype & ~(lvl ^ pol));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= lvl;
      edge_q <= edge_d;
    end
  end

  assign irq = |(en & stat);

  // R11: an edge meeting a clear in the same cycle survives
  a_r11_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & hit) != '0) |=> ((edge_q & $past(clr & hit)) == $past(clr & hit)));

  // R10: a clear with no fresh edge empties the bit
  a_r10_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~hit) != '0) |=> ((edge_q & $past(clr & ~hit)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PIN_CNT = 31,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [3:0]         bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [PIN_CNT-1:0] pad_in,
  output logic [PIN_CNT-1:0] pad_out,
  output logic [PIN_CNT-1:0] pad_oe,
  output logic [PIN_CNT-1:0] pad_pu,
  output logic [PIN_CNT-1:0] pad_pd,
  input  logic [PIN_CNT-1:0] alt_out,
  input  logic [PIN_CNT-1:0] alt_oe,
  output logic               irq
);
  localparam int N   = PIN_CNT;
  localparam int PPR = DW / 2;

  logic         wr_en, w_dout, w_oes, w_oec, w_alt, w_ien, w_ityp, w_ipol, w_istat;
  logic [N-1:0] wbits;
  logic [N-1:0] dout_q, dout_d, oe_q, oe_d, alt_q, alt_d;
  logic [N-1:0] ien_q, ien_d, ityp_q, ityp_d, ipol_q, ipol_d;
  logic [N-1:0] din, istat;
  logic [N-1:0][1:0] pull_q, pull_d;
  logic [DW-1:0] pull_ra, pull_rb;

  assign wr_en   = bus_sel & bus_wr;
  assign wbits   = bus_wdata[N-1:0];
  assign w_dout  = wr_en && (bus_addr == REG_DOUT);
  assign w_oes   = wr_en && (bus_addr == REG_OE_SET);
  assign w_oec   = wr_en && (bus_addr == REG_OE_CLR);
  assign w_alt   = wr_en && (bus_addr == REG_ALT);
  assign w_ien   = wr_en && (bus_addr == REG_IEN);
  assign w_ityp  = wr_en && (bus_addr == REG_ITYPE);
  assign w_ipol  = wr_en && (bus_addr == REG_IPOL);
  assign w_istat = wr_en && (bus_addr == REG_ISTAT);

  // next-state logic for the control registers
  always_comb begin
    dout_d = w_dout ? wbits : dout_q;
    oe_d   = (oe_q | (w_oes ? wbits : '0)) & ~(w_oec ? wbits : '0);
    alt_d  = w_alt  ? wbits : alt_q;
    ien_d  = w_ien  ? wbits : ien_q;
    ityp_d = w_ityp ? wbits : ityp_q;
    ipol_d = w_ipol ? wbits : ipol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      alt_q  <= '0;
      ien_q  <= '0;
      ityp_q <= '0;
      ipol_q <= '0;
      pull_q <= {N{PULL_UP}};
    end else begin
      dout_q <= dout_d;
      oe_q   <= oe_d;
      alt_q  <= alt_d;
      ien_q  <= ien_d;
      ityp_q <= ityp_d;
      ipol_q <= ipol_d;
      pull_q <= pull_d;
    end
  end

  // per-pin pull field: its register and bit slot follow from the pin index
  for (genvar gi = 0; gi < N; gi++) begin : g_pin
    localparam int RIDX = int'(REG_PULL_A) + gi / PPR;
    localparam int LSB  = 2 * (gi % PPR);
    assign pull_d[gi] = (wr_en && (bus_addr == 4'(RIDX))) ? bus_wdata[LSB +: 2] : pull_q[gi];
    assign pad_pu[gi] = (pull_q[gi] == PULL_UP);
    assign pad_pd[gi] = (pull_q[gi] == PULL_DOWN);
  end

  always_comb begin
    pull_ra = '0;
    pull_rb = '0;
    for (int i = 0; i < N; i++) begin
      if (i < PPR) pull_ra[2*i +: 2] = pull_q[i];
      else         pull_rb[2*(i-PPR) +: 2] = pull_q[i];
    end
  end

  gpio_sync #(.W(N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (din)
  );

  gpio_irq #(.W(N)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (din),
    .en      (ien_q),
    .etype   (ityp_q),
    .pol     (ipol_q),
    .clr_we  (w_istat),
    .clr_mask(wbits),
    .stat    (istat),
    .irq     (irq)
  );

  assign pad_out = (alt_q & alt_out) | (~alt_q & dout_q);
  assign pad_oe  = (alt_q & alt_oe)  | (~alt_q & oe_q);

  always_comb begin
    case (bus_addr)
      REG_DIN:    bus_rdata = DW'(din);
      REG_DOUT:   bus_rdata = DW'(dout_q);
      REG_OE_SET: bus_rdata = DW'(oe_q);
      REG_OE_CLR: bus_rdata = DW'(oe_q);
      REG_ALT:    bus_rdata = DW'(alt_q);
      REG_PULL_A: bus_rdata = pull_ra;
      REG_PULL_B: bus_rdata = pull_rb;
      REG_IEN:    bus_rdata = DW'(ien_q);
      REG_ITYPE:  bus_rdata = DW'(ityp_q);
      REG_IPOL:   bus_rdata = DW'(ipol_q);
      REG_ISTAT:  bus_rdata = DW'(istat);
      default:    bus_rdata = '0;
    endcase
  end

  // R2: set-register write turns on every addressed direction bit
  a_r2_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
    w_oes |=> ((oe_q & $past(wbits)) == $past(wbits)));

  // R3: clear-register write turns off every addressed direction bit
  a_r3_oe_clr: assert property (@(posedge clk) disable iff (!rst_n)
    w_oec |=> ((oe_q & $past(wbits)) == '0));

  // R4: the output latch holds through any access that does not target it
  a_r4_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !w_dout |=> $stable(dout_q));

  // R9: an enabled level pin at its active level raises the interrupt
  a_r9_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q & ~ityp_q & ~(din ^ ipol_q)) != '0) |-> irq);
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int N = 31;
  localparam logic [31:0] PM = 32'h7FFF_FFFF;

  logic clk, rst_n, bus_sel, bus_wr, irq;
  logic [3:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rd;
  logic [N-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd, alt_out, alt_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_port #(.PIN_CNT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd2,  32'h0000_000F, 4'd2,  32'h0000_000F, 8'd2},  // R2 set
    '{4'd2,  32'h0000_0030, 4'd3,  32'h0000_003F, 8'd2},  // R2 readable at clear address
    '{4'd3,  32'h0000_0005, 4'd2,  32'h0000_003A, 8'd3},  // R3 clear
    '{4'd3,  32'h0000_0000, 4'd2,  32'h0000_003A, 8'd3},  // R3 zero bits no effect
    '{4'd1,  32'hFFFF_FFFF, 4'd1,  32'h7FFF_FFFF, 8'd8},  // R8 bit 31 absent
    '{4'd1,  32'h0000_A5A5, 4'd1,  32'h0000_A5A5, 8'd4},  // R4 latch
    '{4'd15, 32'h0000_1234, 4'd15, 32'h0000_0000, 8'd8},  // R8 unmapped
    '{4'd6,  32'hFFFF_FFFF, 4'd6,  32'h3FFF_FFFF, 8'd8}   // R8 pins 16..30 only
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    pad_in = '1; alt_out = '0; alt_oe = '0;
    tick(3);
    rst_n = 1;
    tick(3);

    // R1 reset state
    check(32'(pad_oe), 32'h0, "R1 pad_oe");
    check(32'(pad_pu), PM, "R1 pad_pu");
    check(32'(pad_pd), 32'h0, "R1 pad_pd");
    check({31'h0, irq}, 32'h0, "R1 irq");
    bus_read(4'd1, rd); check(rd, 32'h0, "R1 latch");
    bus_read(4'd4, rd); check(rd, 32'h0, "R1 alt select");
    bus_read(4'd5, rd); check(rd, 32'h5555_5555, "R1 pull fields");

    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i].wa, VEC[i].wd);
      bus_read(VEC[i].ra, rd);
      check(rd, VEC[i].ex, $sformatf("R%0d vector %0d", VEC[i].rq, i));
    end

    // R4 output follows latch and direction; latch survives input phase
    check(32'(pad_out), 32'h0000_A5A5, "R4 pad_out");
    check(32'(pad_oe), 32'h0000_003A, "R4 pad_oe");
    bus_write(4'd3, 32'hFFFF_FFFF);
    check(32'(pad_oe), 32'h0, "R4 all inputs");
    check(32'(pad_out), 32'h0000_A5A5, "R4 latch kept as input");
    bus_write(4'd2, 32'h0000_FFFF);
    check(32'(pad_out), 32'h0000_A5A5, "R4 latch driven again");
    check(32'(pad_oe), 32'h0000_FFFF, "R4 direction restored");

    // R6 alternate function override
    alt_out = 31'h0F0F_0F0F; alt_oe = 31'h00FF_0000;
    bus_write(4'd4, 32'h0000_FF00);
    check(32'(pad_out), (32'h0000_A5A5 & ~32'hFF00) | (32'h0F0F_0F0F & 32'hFF00), "R6 pad_out");
    check(32'(pad_oe), (32'h0000_FFFF & ~32'hFF00) | (32'h00FF_0000 & 32'hFF00), "R6 pad_oe");
    bus_write(4'd4, 32'h0);
    check(32'(pad_out), 32'h0000_A5A5, "R6 override released");

    // R5 two-flop latency, visible on output pins too
    pad_in = '0;
    tick(1);
    bus_read(4'd0, rd); check(rd, PM, "R5 after one edge");
    tick(1);
    bus_read(4'd0, rd); check(rd, 32'h0, "R5 after two edges");

    // R7 pull encodings: pin0 down, pin1 up, pin2 3, pin3 0
    bus_write(4'd5, 32'h0000_0036);
    check(32'(pad_pu[3:0]), 32'h2, "R7 pull-up enables");
    check(32'(pad_pd[3:0]), 32'h1, "R7 pull-down enables");

    // R9 level interrupt on pin 3 (input low)
    bus_write(4'd9, 32'h0000_0008);
    bus_write(4'd7, 32'h0000_0008);
    check({31'h0, irq}, 32'h0, "R9 wrong level no irq");
    bus_write(4'd9, 32'h0);
    check({31'h0, irq}, 32'h1, "R9 active-low level irq");
    bus_read(4'd10, rd); check(rd & 32'h8, 32'h8, "R9 level status");
    bus_write(4'd7, 32'h0);
    check({31'h0, irq}, 32'h0, "R12 masked by enable");

    // R10/R11 rising edge on pin 0
    bus_write(4'd8, 32'h1);
    bus_write(4'd9, 32'h1);
    bus_write(4'd7, 32'h1);
    bus_write(4'd10, 32'hFFFF_FFFF);
    bus_read(4'd10, rd); check(rd & 32'h1, 32'h0, "R10 status clear start");
    pad_in[0] = 1'b1;
    tick(2);
    check({31'h0, irq}, 32'h0, "R10 not yet latched");
    bus_write(4'd10, 32'h1);
    check({31'h0, irq}, 32'h1, "R11 edge kept over clear");
    bus_write(4'd10, 32'h0);
    check({31'h0, irq}, 32'h1, "R10 zero write keeps status");
    bus_write(4'd10, 32'h1);
    check({31'h0, irq}, 32'h0, "R10 write-one clears");
    pad_in[0] = 1'b0;
    tick(4);
    check({31'h0, irq}, 32'h0, "R10 falling edge ignored");
    bus_read(4'd10, rd); check(rd & 32'h1, 32'h0, "R10 status after falling");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule